// File: doc/BRIEF.md
# Multiprocessor-Capable 9-Bit Serial Port

This block is a full-duplex asynchronous serial port. Software controls it through two byte-wide registers on a simple CPU bus: one control/status byte and one data byte. The control byte picks the frame format and bit-rate source, turns the receiver on or off, supplies the ninth bit for outgoing frames, returns the ninth (or stop) bit of the last accepted frame, and holds two completion flags. These flags drive the interrupt outputs and stay set until software clears them.

Frames are sent and received least significant bit first. Each frame has one low start bit, eight data bits, an optional ninth bit and one high stop bit. Every bit lasts a fixed number of bit-rate ticks. The receiver looks for a start bit on every tick, confirms it at mid-bit and then samples each later bit at its centre. When the multiprocessor filter is on, the receiver drops frames that are not addresses, so a node on a shared line is woken only by frames meant to select a station.

The rate source depends on the mode. One 9-bit mode uses an internal fixed division of the system clock. The other two active modes count an external tick input.

Top module: `mp_uart9`

## Requirements
- R1: After reset the control byte and the receive buffer read 0, `tx_o` is high, and both interrupt outputs are low.
- R2: Control bits [7:6] select the mode: 01 = 8-bit frames on the external tick, 10 = 9-bit frames on the internal fixed rate, 11 = 9-bit frames on the external tick. 00 disables the port: a data write starts no frame, and no received frame sets any flag.
- R3: A frame is accepted only while control bit 4 (receive enable) is 1. With it at 0, incoming frames change neither the flags nor the buffer.
- R4: A transmitted frame is a low start bit, then data bits 0 to 7, then, in the 9-bit modes, control bit 3 as the ninth bit, then a high stop bit.
- R5: Writing the data address (1) while the transmitter is idle starts a frame. A data write while a frame is in progress is ignored and queues nothing.
- R6: Control bit 1 (transmit flag, mirrored on `irq_tx`) is set when the stop bit of a frame ends. Hardware never clears it. Software clears it by writing the control byte with that bit at 0.
- R7: Control bit 0 (receive flag, mirrored on `irq_rx`) is set when a frame is accepted, and only software clears it. At the same time the received byte is loaded into the buffer that is read at the data address.
- R8: In the 9-bit modes with control bit 5 (multiprocessor filter) at 0, every frame is accepted and its ninth bit is stored in control bit 2.
- R9: In 8-bit mode with the filter off, every frame is accepted, including one with a low stop bit, and the stop bit is stored in control bit 2.
- R10: In the 9-bit modes with the filter on, a frame whose ninth bit is 0 leaves the flag, control bit 2 and the buffer unchanged. A frame whose ninth bit is 1 is accepted.
- R11: In 8-bit mode with the filter on, a frame is accepted only if its stop bit is high.
- R12: If the line has returned high by the middle of the start bit, the receiver drops the start and does not set the flag. It can then take the next valid frame.
- R13: Each bit lasts OVS ticks. In modes 01 and 11 a tick is a cycle with `baud_tick` high. In mode 10 a tick comes every FIX_DIV clocks, whatever `baud_tick` does. A 9-bit frame therefore sets the transmit flag exactly 11*OVS ticks after the data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control byte, 1 = data (write: transmit, read: receive buffer) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| baud_tick | input | 1 | External oversampling tick, OVS per bit |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line, idle high |
| irq_tx | output | 1 | Transmit-done flag |
| irq_rx | output | 1 | Receive-done flag |

## Verification
The bench sweeps every active mode, filter setting and ninth/stop value against a few data bytes, and predicts acceptance, the stored ninth bit and the buffer from the requirement rules. A design that swapped the ninth and stop bits, filtered in the wrong polarity, or loaded the buffer on rejected frames would show a wrong flag or a wrong byte. The bench also targets a frame with a low stop bit, which must not leave the receiver stuck or start a ghost frame, and a glitch shorter than half a bit. For flag timing, it counts cycles from the data write to the flag, and it holds the external tick low to show that mode 10 ignores that input while mode 11 stalls. A second data write during a frame is checked through a loopback: exactly one frame must go out, and it must carry the first byte.

// File: rtl/uart9_pkg.sv
`timescale 1ns/1ps
package uart9_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_8EXT = 2'b01,
    MODE_9FIX = 2'b10,
    MODE_9EXT = 2'b11
  } uart_mode_e;

  // Control byte, MSB first; field positions are software visible.
  typedef struct packed {
    uart_mode_e mode;     // [7:6]
    logic       mp_en;    // [5]
    logic       rx_en;    // [4]
    logic       tx_b9;    // [3]
    logic       rx_b9;    // [2]
    logic       tx_flag;  // [1]
    logic       rx_flag;  // [0]
  } uart_ctrl_t;

  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_DATA = 1'b1;

endpackage

// File: rtl/uart9_tickgen.sv
`timescale 1ns/1ps
module uart9_tickgen
  import uart9_pkg::*;
#(
  parameter int unsigned FIX_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  uart_mode_e mode,
  input  logic       ext_tick,
  output logic       tick
);

  logic fix_tick;

  generate
    if (FIX_DIV > 1) begin : g_div
      localparam int unsigned DW = $clog2(FIX_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(FIX_DIV - 1);
      logic [DW-1:0] div_q, div_d;

      always_comb begin
        div_d = '0;
        if (mode == MODE_9FIX) begin
          div_d = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign fix_tick = (div_q == DIV_LAST);
    end else begin : g_nodiv
      assign fix_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    case (mode)
      MODE_OFF:  tick = 1'b0;
      MODE_9FIX: tick = fix_tick;
      default:   tick = ext_tick;
    endcase
  end

endmodule

// File: rtl/uart9_tx.sv
`timescale 1ns/1ps
module uart9_tx #(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       nine,
  input  logic       tb9,
  input  logic [7:0] data,
  output logic       tx,
  output logic       busy,
  output logic       done
);

  localparam int unsigned OW = $clog2(OVS);
  localparam logic [OW-1:0] OVS_LAST = OW'(OVS - 1);
  localparam int unsigned FW = 11;

  logic [FW-1:0] sh_q, sh_d;
  logic [3:0]    left_q, left_d;
  logic [OW-1:0] ovs_q, ovs_d;
  logic          busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    ovs_d  = ovs_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        // stop, ninth (or second stop), data, start: shifted out from bit 0
        sh_d   = {1'b1, (nine ? tb9 : 1'b1), data, 1'b0};
        left_d = nine ? 4'd11 : 4'd10;
        ovs_d  = '0;
        busy_d = 1'b1;
      end
    end else if (tick) begin
      if (ovs_q == OVS_LAST) begin
        ovs_d  = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - 4'd1;
        if (left_q == 4'd1) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end
      end else begin
        ovs_d = ovs_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      ovs_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      ovs_q  <= ovs_d;
      busy_q <= busy_d;
    end
  end

  assign tx   = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;

endmodule

// File: rtl/uart9_rx.sv
`timescale 1ns/1ps
module uart9_rx #(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       nine,
  input  logic       rx_s,
  output logic       done,
  output logic [7:0] data,
  output logic       ninth,
  output logic       stop
);

  localparam int unsigned OW = $clog2(OVS);
  localparam logic [OW-1:0] OVS_LAST  = OW'(OVS - 1);
  localparam logic [OW-1:0] HALF_LAST = OW'(OVS / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_SHIFT, RX_HOLD} rx_state_e;

  rx_state_e     st_q, st_d;
  logic [OW-1:0] ovs_q, ovs_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [9:0]    sh_q, sh_d;
  logic          nine_q, nine_d;
  logic          done_q, done_d;
  logic [3:0]    last_idx;

  assign last_idx = nine_q ? 4'd9 : 4'd8;

  always_comb begin
    st_d   = st_q;
    ovs_d  = ovs_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    nine_d = nine_q;
    done_d = 1'b0;
    if (!enable) begin
      st_d  = RX_IDLE;
      ovs_d = '0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (tick && !rx_s) begin
            st_d   = RX_START;
            ovs_d  = '0;
            nine_d = nine;
          end
        end
        RX_START: begin
          if (tick) begin
            if (ovs_q == HALF_LAST) begin
              ovs_d = '0;
              cnt_d = '0;
              st_d  = rx_s ? RX_IDLE : RX_SHIFT;
            end else begin
              ovs_d = ovs_q + 1'b1;
            end
          end
        end
        RX_SHIFT: begin
          if (tick) begin
            if (ovs_q == OVS_LAST) begin
              ovs_d = '0;
              sh_d  = {rx_s, sh_q[9:1]};
              cnt_d = cnt_q + 4'd1;
              if (cnt_q == last_idx) begin
                done_d = 1'b1;
                st_d   = RX_HOLD;
              end
            end else begin
              ovs_d = ovs_q + 1'b1;
            end
          end
        end
        default: begin
          // wait for the line to go high again before hunting a start bit
          if (rx_s) st_d = RX_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      ovs_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      nine_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ovs_q  <= ovs_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      nine_q <= nine_d;
      done_q <= done_d;
    end
  end

  assign done  = done_q;
  assign data  = nine_q ? sh_q[7:0] : sh_q[8:1];
  assign ninth = sh_q[8];
  assign stop  = sh_q[9];

endmodule

// File: rtl/mp_uart9.sv
`timescale 1ns/1ps
module mp_uart9
  import uart9_pkg::*;
#(
  parameter int unsigned OVS     = 16,
  parameter int unsigned FIX_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       baud_tick,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       irq_tx,
  output logic       irq_rx
);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [1:0] rx_sync_q;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rx_sync_q <= 2'b11;
    else          rx_sync_q <= {rx_sync_q[0], rx_i};
  end

  uart_ctrl_t ctrl_q, ctrl_d;
  logic [7:0] rbuf_q, rbuf_d;
  logic       wr_ctrl, wr_data, active, nine, tick;
  logic       tx_busy, tx_done, rx_done, rx_ninth, rx_stop, rx_on, accept;
  logic [7:0] rx_data;

  assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign wr_data = reg_wr && (reg_addr == REG_DATA);
  assign active  = (ctrl_q.mode != MODE_OFF);
  assign nine    = ctrl_q.mode[1];
  assign rx_on   = active && ctrl_q.rx_en;

  uart9_tickgen #(.FIX_DIV(FIX_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n_i), .mode(ctrl_q.mode),
    .ext_tick(baud_tick), .tick(tick)
  );

  uart9_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .tick(tick),
    .start(wr_data && active), .nine(nine), .tb9(ctrl_q.tx_b9),
    .data(reg_wdata), .tx(tx_o), .busy(tx_busy), .done(tx_done)
  );

  uart9_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n_i), .tick(tick), .enable(rx_on),
    .nine(nine), .rx_s(rx_sync_q[1]), .done(rx_done),
    .data(rx_data), .ninth(rx_ninth), .stop(rx_stop)
  );

  always_comb begin
    accept = 1'b0;
    if (rx_done && rx_on) begin
      if (nine) accept = !ctrl_q.mp_en || rx_ninth;
      else      accept = !ctrl_q.mp_en || rx_stop;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    rbuf_d = rbuf_q;
    if (wr_ctrl) ctrl_d = uart_ctrl_t'(reg_wdata);
    if (tx_done) ctrl_d.tx_flag = 1'b1;
    if (accept) begin
      ctrl_d.rx_flag = 1'b1;
      ctrl_d.rx_b9   = nine ? rx_ninth : rx_stop;
      rbuf_d         = rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q <= '0;
      rbuf_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign reg_rdata = (reg_addr == REG_DATA) ? rbuf_q : 8'(ctrl_q);
  assign irq_tx    = ctrl_q.tx_flag;
  assign irq_rx    = ctrl_q.rx_flag;

endmodule

// File: rtl/uart9_chk.sv
`timescale 1ns/1ps
module uart9_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctrl,
  input logic       wr_data,
  input logic [1:0] mode,
  input logic       mp_en,
  input logic       rx_en,
  input logic       tx_flag,
  input logic       rx_flag,
  input logic       rx_done,
  input logic       rx_ninth,
  input logic       tx_busy,
  input logic       tx_line
);

  p_tflag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flag && !wr_ctrl) |=> tx_flag);

  p_rflag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !wr_ctrl) |=> rx_flag);

  p_rx_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_flag && !wr_ctrl) |=> !rx_flag);

  p_mp_filter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && mode[1] && mp_en && !rx_ninth && !rx_flag && !wr_ctrl) |=> !rx_flag);

  p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && wr_data && !tx_busy) |=> !tx_busy);

  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_line);

endmodule

bind mp_uart9 uart9_chk u_chk (
  .clk(clk), .rst_n(rst_n_i), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
  .mode(ctrl_q.mode), .mp_en(ctrl_q.mp_en), .rx_en(ctrl_q.rx_en),
  .tx_flag(ctrl_q.tx_flag), .rx_flag(ctrl_q.rx_flag), .rx_done(rx_done),
  .rx_ninth(rx_ninth), .tx_busy(tx_busy), .tx_line(tx_o)
);

// File: tb/mp_uart9_tb.sv
`timescale 1ns/1ps
module mp_uart9_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int FIX_DIV    = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       baud_tick, rx_line, loop_en, rx_i, tx_o, irq_tx, irq_rx;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign rx_i = loop_en ? tx_o : rx_line;

  mp_uart9 #(.OVS(OVS), .FIX_DIV(FIX_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
    .rx_i(rx_i), .tx_o(tx_o), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  // control byte: mode[7:6] filter[5] rx enable[4] tx ninth[3], flags cleared
  function automatic logic [7:0] cw(input logic [1:0] m, input logic mp,
                                    input logic re, input logic t9);
    return {m, mp, re, t9, 3'b000};
  endfunction

  task automatic rx_send(input logic [7:0] d, input bit has9, input logic b9,
                         input logic stp);
    rx_line = 1'b0;
    repeat (OVS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      repeat (OVS) @(negedge clk);
    end
    if (has9) begin
      rx_line = b9;
      repeat (OVS) @(negedge clk);
    end
    rx_line = stp;
    repeat (OVS) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * OVS) @(negedge clk);
  endtask

  task automatic tx_grab(input bit has9, input int bitclk, output logic [7:0] d,
                         output logic b9, output logic stp, output bit seen);
    seen = 1'b0;
    d = '0; b9 = 1'b0; stp = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (!tx_o) seen = 1'b1;
    end
    repeat (bitclk / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (bitclk) @(negedge clk);
      d[i] = tx_o;
    end
    if (has9) begin
      repeat (bitclk) @(negedge clk);
      b9 = tx_o;
    end
    repeat (bitclk) @(negedge clk);
    stp = tx_o;
  endtask

  task automatic wait_ti(output int cnt);
    cnt = 0;
    while (!irq_tx && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, pre, d;
    logic       b9, stp;
    bit         seen;
    int         cnt, lows;
    logic [7:0] txd[5]  = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    logic [7:0] accd[3] = '{8'h6B, 8'hFE, 8'h3C};
    logic [7:0] rejd[3] = '{8'hC0, 8'hC1, 8'hC2};

    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    baud_tick = 1'b1; rx_line = 1'b1; loop_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 0);
    rd(1'b1, v); chk("R1 rxbuf", v, 0);
    chk("R1 tx idle", tx_o, 1);
    chk("R1 irq_tx", irq_tx, 0);
    chk("R1 irq_rx", irq_rx, 0);

    // R4/R6 transmit sweep over modes 01 and 11, ninth bit and data
    for (int mi = 0; mi < 2; mi++) begin
      for (int t9 = 0; t9 < 2; t9++) begin
        for (int di = 0; di < 5; di++) begin
          logic [1:0] m;
          bit has9;
          m = (mi == 0) ? 2'b01 : 2'b11;
          has9 = m[1];
          wr(1'b0, cw(m, 1'b0, 1'b0, 1'(t9)));
          wr(1'b1, txd[di]);
          chk("R6 tflag clear while sending", irq_tx, 0);
          tx_grab(has9, OVS, d, b9, stp, seen);
          chk("R4 start bit seen", seen, 1);
          chk("R4 data bits", d, txd[di]);
          if (has9) chk("R4 ninth bit", b9, t9);
          chk("R4 stop bit", stp, 1);
          wait_ti(cnt);
          chk("R6 tflag set", irq_tx, 1);
        end
      end
    end

    // R6 flag held until software write
    repeat (50) @(negedge clk);
    chk("R6 tflag sticky", irq_tx, 1);
    rd(1'b0, v); chk("R6 ctrl bit1", v[1], 1);
    wr(1'b0, cw(2'b11, 1'b0, 1'b0, 1'b0));
    chk("R6 tflag cleared", irq_tx, 0);

    // R13 exact flag timing, external tick every cycle
    wr(1'b0, cw(2'b11, 1'b0, 1'b0, 1'b0));
    wr(1'b1, 8'h55); wait_ti(cnt);
    chk("R13 9-bit ext frame cycles", cnt, 11 * OVS);
    wr(1'b0, cw(2'b01, 1'b0, 1'b0, 1'b0));
    wr(1'b1, 8'h55); wait_ti(cnt);
    chk("R13 8-bit ext frame cycles", cnt, 10 * OVS);

    // R13 external-tick mode stalls without ticks
    baud_tick = 1'b0;
    wr(1'b0, cw(2'b11, 1'b0, 1'b0, 1'b0));
    wr(1'b1, 8'hF0);
    repeat (500) @(negedge clk);
    chk("R13 stalled start bit", tx_o, 0);
    chk("R13 stalled no flag", irq_tx, 0);
    baud_tick = 1'b1;
    wait_ti(cnt);
    chk("R13 resumed frame cycles", cnt, 11 * OVS);

    // R13 fixed-rate mode ignores baud_tick
    baud_tick = 1'b0;
    wr(1'b0, cw(2'b10, 1'b0, 1'b0, 1'b1));
    wr(1'b1, 8'h96); wait_ti(cnt);
    chk("R13 fixed-rate cycles in range",
        int'(cnt >= 11 * OVS * FIX_DIV - 4 && cnt <= 11 * OVS * FIX_DIV + 4), 1);
    wr(1'b0, cw(2'b10, 1'b0, 1'b0, 1'b1));
    wr(1'b1, 8'h96);
    tx_grab(1'b1, OVS * FIX_DIV, d, b9, stp, seen);
    chk("R13 fixed-rate data", d, 8'h96);
    chk("R13 fixed-rate ninth", b9, 1);
    wait_ti(cnt);
    baud_tick = 1'b1;

    // R2 mode 00: no transmit, no receive
    wr(1'b0, cw(2'b00, 1'b0, 1'b1, 1'b0));
    wr(1'b1, 8'h33);
    lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!tx_o) lows++;
    end
    chk("R2 mode off line idle", lows, 0);
    chk("R2 mode off no tflag", irq_tx, 0);
    rx_send(8'h77, 1'b1, 1'b1, 1'b1);
    chk("R2 mode off no rflag", irq_rx, 0);

    // R7-R11 receive sweep
    for (int mi = 0; mi < 2; mi++) begin
      for (int mp = 0; mp < 2; mp++) begin
        for (int fb = 0; fb < 2; fb++) begin
          for (int di = 0; di < 3; di++) begin
            logic [1:0] m;
            bit has9, acc;
            string tag;
            m    = (mi == 0) ? 2'b01 : 2'b11;
            has9 = m[1];
            acc  = (mp == 0) || (fb == 1);
            d    = acc ? accd[di] : rejd[di];
            if (has9) tag = (mp != 0) ? "R10" : "R8";
            else      tag = (mp != 0) ? "R11" : "R9";
            rd(1'b1, pre);
            wr(1'b0, cw(m, 1'(mp), 1'b1, 1'b0));
            rx_send(d, has9, 1'(fb), has9 ? 1'b1 : 1'(fb));
            rd(1'b0, v);
            chk({tag, " rflag"}, v[0], int'(acc));
            chk({tag, " stored ninth/stop"}, v[2], acc ? fb : 0);
            rd(1'b1, v);
            chk({tag, " R7 buffer"}, v, acc ? d : pre);
          end
        end
      end
    end
    chk("R7 irq_rx mirrors flag", irq_rx, 1);

    // R3 receive disabled
    rd(1'b1, pre);
    wr(1'b0, cw(2'b11, 1'b0, 1'b0, 1'b0));
    rx_send(8'h99, 1'b1, 1'b1, 1'b1);
    chk("R3 no rflag when disabled", irq_rx, 0);
    rd(1'b1, v); chk("R3 buffer unchanged", v, pre);

    // R12 false start then a valid frame
    wr(1'b0, cw(2'b11, 1'b0, 1'b1, 1'b0));
    @(negedge clk); rx_line = 1'b0;
    repeat (4) @(negedge clk); rx_line = 1'b1;
    repeat (300) @(negedge clk);
    chk("R12 glitch rejected", irq_rx, 0);
    rx_send(8'h42, 1'b1, 1'b1, 1'b1);
    chk("R12 next frame accepted", irq_rx, 1);
    rd(1'b1, v); chk("R12 next frame data", v, 8'h42);

    // R5 write during busy ignored (loopback)
    loop_en = 1'b1;
    wr(1'b0, cw(2'b11, 1'b0, 1'b1, 1'b1));
    wr(1'b1, 8'h5A);
    repeat (20) @(negedge clk);
    wr(1'b1, 8'hC3);
    wait_ti(cnt);
    chk("R5 first frame cycles", cnt, 11 * OVS - 22);
    repeat (3 * OVS) @(negedge clk);
    rd(1'b1, v); chk("R5 looped byte", v, 8'h5A);
    rd(1'b0, v); chk("R8 looped ninth", v[2], 1);
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!tx_o) lows++;
    end
    chk("R5 no second frame", lows, 0);
    loop_en = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule